// File: doc/BRIEF.md
# Pipeline Load-Use Hazard and Operand Forwarding Control

This block decides, for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback), where each operand should come from and when the front of the pipeline must wait. It looks only at register numbers and a few control flags held in the pipeline registers. From these it produces mux selects for the two execute-stage ALU operands, a select for the memory-stage store-data path, and the hold and bubble controls for fetch and decode. Every output is combinational. The datapath, register file, memories and branch logic live elsewhere.

A load's result exists only at the end of the memory stage. An instruction in decode that needs that result in execute must therefore wait one cycle. A store differs from other consumers. Its base register feeds the address adder in execute, where the base plus a sign-extended 16-bit offset forms the address, so the base behaves like any ALU operand. Its data register is not needed until the memory stage. With the optional store-data path enabled (`STORE_FWD_EN`), the loaded value is taken from the writeback stage straight into the store's memory stage. A load followed at once by a store of the loaded value then runs back-to-back. A store whose base is the loaded register still waits one cycle.

Top module: `hz_fwd_unit`

## Requirements
- R1: Register 0 is never a forwarding source or a hazard source: a source number of 0 always gives select 2'b00, and a destination of 0 never raises a hold or `sd_fwd`.
- R2: Each execute operand select is 2'b10 (result of the instruction in memory) when the memory stage writes that register and is not a load. Otherwise it is 2'b01 (writeback result) when the writeback stage writes it. Otherwise it is 2'b00 (register file). The memory stage takes priority over writeback.
- R3: When the memory stage holds a load whose destination matches an execute operand, that operand's select is 2'b00. The older writeback value is not chosen.
- R4: A load in execute followed in decode by a non-store instruction that reads the loaded register sets `pc_hold`, `ifid_hold` and `idex_bubble` to 1 together for that cycle.
- R5: A load in execute followed in decode by a store whose data register (source 2) alone matches the load's destination gives no hold when `STORE_FWD_EN`=1, and a one-cycle hold when `STORE_FWD_EN`=0.
- R6: A load in execute followed in decode by a store whose base register (source 1) matches the load's destination gives a hold for either setting of `STORE_FWD_EN`.
- R7: `sd_fwd` is 1 exactly when `STORE_FWD_EN`=1, the memory stage is a store, its data register is nonzero, and it equals the register being written by the writeback stage. With `STORE_FWD_EN`=0, `sd_fwd` is always 0.
- R8: When the instruction in execute is not a load, no hold is raised, even if decode reads the same registers that execute reads or writes.
- R9: A source whose used flag is 0 neither forwards (select 2'b00) nor causes a hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src1 | input | REG_W | Decode-stage source 1 (base register for a store) |
| id_src2 | input | REG_W | Decode-stage source 2 (data register for a store) |
| id_src1_used | input | 1 | Decode source 1 is read |
| id_src2_used | input | 1 | Decode source 2 is read |
| id_store | input | 1 | Decode instruction is a store |
| ex_src1 | input | REG_W | Execute-stage source 1 |
| ex_src2 | input | REG_W | Execute-stage source 2 |
| ex_src1_used | input | 1 | Execute source 1 is read |
| ex_src2_used | input | 1 | Execute source 2 is read |
| ex_dst | input | REG_W | Execute-stage destination |
| ex_wr | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_dst | input | REG_W | Memory-stage destination |
| mem_wr | input | 1 | Memory instruction writes a register |
| mem_load | input | 1 | Memory instruction is a load |
| mem_store | input | 1 | Memory instruction is a store |
| mem_sdata_reg | input | REG_W | Memory-stage store data register |
| wb_dst | input | REG_W | Writeback-stage destination |
| wb_wr | input | 1 | Writeback instruction writes a register |
| fwd_a_sel | output | 2 | Execute operand 1 select (00 RF, 01 WB, 10 MEM) |
| fwd_b_sel | output | 2 | Execute operand 2 select (00 RF, 01 WB, 10 MEM) |
| sd_fwd | output | 1 | Memory-stage store data taken from writeback result |
| pc_hold | output | 1 | Freeze the program counter |
| ifid_hold | output | 1 | Freeze the fetch/decode register |
| idex_bubble | output | 1 | Clear control bits entering execute |

## Verification
The bench builds two copies of the block side by side: one with `STORE_FWD_EN`=1 and one with `STORE_FWD_EN`=0, both with `REG_W`=5. Both see identical stimulus. This lets a single load-then-store sequence show the missing hold in one copy and the extra hold in the other. Random register numbers are drawn from a narrow range so that matches across stages, and shadowing by a load in the memory stage, happen often. Directed cases cover register 0, the base-versus-data distinction and unused sources.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_EXM = 2'b10
  } fwd_sel_e;

  localparam int unsigned NUM_EX_SRC = 2;

endpackage

// File: rtl/hz_ex_fwd.sv
module hz_ex_fwd
  import hz_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic             src_used,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wr,
  input  logic             mem_load,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wr,
  output fwd_sel_e         sel,
  output logic             mem_hit,
  output logic             wb_hit
);

  function automatic logic live_match(logic [REG_W-1:0] a, logic a_used,
                                      logic [REG_W-1:0] d, logic d_wr);
    return a_used && d_wr && (d != '0) && (a == d);
  endfunction

  assign mem_hit = live_match(src, src_used, mem_dst, mem_wr);
  assign wb_hit  = live_match(src, src_used, wb_dst, wb_wr);

  always_comb begin
    if (mem_hit) begin
      sel = mem_load ? FWD_RF : FWD_EXM;
    end else if (wb_hit) begin
      sel = FWD_WB;
    end else begin
      sel = FWD_RF;
    end
  end

endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int unsigned REG_W        = 5,
  parameter bit          STORE_FWD_EN = 1'b1
) (
  input  logic [REG_W-1:0] id_src1,
  input  logic [REG_W-1:0] id_src2,
  input  logic             id_src1_used,
  input  logic             id_src2_used,
  input  logic             id_store,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_wr,
  input  logic             ex_load,
  output logic             base_hit,
  output logic             data_hit,
  output logic             stall
);

  localparam bit DATA_LATE = STORE_FWD_EN;

  logic load_live;
  logic data_needs_ex;

  assign load_live = ex_load && ex_wr && (ex_dst != '0);
  assign base_hit  = load_live && id_src1_used && (id_src1 == ex_dst);
  assign data_hit  = load_live && id_src2_used && (id_src2 == ex_dst);

  // Source 2 of a store is only needed in memory when the late path exists.
  assign data_needs_ex = !(DATA_LATE && id_store);

  assign stall = base_hit || (data_hit && data_needs_ex);

endmodule

// File: rtl/hz_store_fwd.sv
module hz_store_fwd #(
  parameter int unsigned REG_W        = 5,
  parameter bit          STORE_FWD_EN = 1'b1
) (
  input  logic             mem_store,
  input  logic [REG_W-1:0] mem_sdata_reg,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wr,
  output logic             sd_fwd
);

  generate
    if (STORE_FWD_EN) begin : g_late_path
      assign sd_fwd = mem_store && wb_wr && (mem_sdata_reg != '0)
                      && (mem_sdata_reg == wb_dst);
    end else begin : g_no_path
      logic unused_ok;
      assign unused_ok = ^{mem_store, mem_sdata_reg, wb_dst, wb_wr};
      assign sd_fwd = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
  import hz_pkg::*;
#(
  parameter int unsigned REG_W        = 5,
  parameter bit          STORE_FWD_EN = 1'b1
) (
  input  logic [REG_W-1:0] id_src1,
  input  logic [REG_W-1:0] id_src2,
  input  logic             id_src1_used,
  input  logic             id_src2_used,
  input  logic             id_store,
  input  logic [REG_W-1:0] ex_src1,
  input  logic [REG_W-1:0] ex_src2,
  input  logic             ex_src1_used,
  input  logic             ex_src2_used,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_wr,
  input  logic             ex_load,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wr,
  input  logic             mem_load,
  input  logic             mem_store,
  input  logic [REG_W-1:0] mem_sdata_reg,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wr,
  output logic [1:0]       fwd_a_sel,
  output logic [1:0]       fwd_b_sel,
  output logic             sd_fwd,
  output logic             pc_hold,
  output logic             ifid_hold,
  output logic             idex_bubble
);

  logic [REG_W-1:0] ex_src  [NUM_EX_SRC];
  logic             ex_used [NUM_EX_SRC];
  fwd_sel_e         ex_sel  [NUM_EX_SRC];
  logic             ex_mem_hit [NUM_EX_SRC];
  logic             ex_wb_hit  [NUM_EX_SRC];

  assign ex_src[0]  = ex_src1;
  assign ex_src[1]  = ex_src2;
  assign ex_used[0] = ex_src1_used;
  assign ex_used[1] = ex_src2_used;

  generate
    for (genvar k = 0; k < NUM_EX_SRC; k++) begin : g_opnd
      hz_ex_fwd #(.REG_W(REG_W)) u_fwd (
        .src      (ex_src[k]),
        .src_used (ex_used[k]),
        .mem_dst  (mem_dst),
        .mem_wr   (mem_wr),
        .mem_load (mem_load),
        .wb_dst   (wb_dst),
        .wb_wr    (wb_wr),
        .sel      (ex_sel[k]),
        .mem_hit  (ex_mem_hit[k]),
        .wb_hit   (ex_wb_hit[k])
      );
    end
  endgenerate

  assign fwd_a_sel = ex_sel[0];
  assign fwd_b_sel = ex_sel[1];

  // Named events for the checker.
  logic lu_base_hit;
  logic lu_data_hit;
  logic lu_stall;

  hz_load_use #(.REG_W(REG_W), .STORE_FWD_EN(STORE_FWD_EN)) u_lu (
    .id_src1      (id_src1),
    .id_src2      (id_src2),
    .id_src1_used (id_src1_used),
    .id_src2_used (id_src2_used),
    .id_store     (id_store),
    .ex_dst       (ex_dst),
    .ex_wr        (ex_wr),
    .ex_load      (ex_load),
    .base_hit     (lu_base_hit),
    .data_hit     (lu_data_hit),
    .stall        (lu_stall)
  );

  assign pc_hold     = lu_stall;
  assign ifid_hold   = lu_stall;
  assign idex_bubble = lu_stall;

  hz_store_fwd #(.REG_W(REG_W), .STORE_FWD_EN(STORE_FWD_EN)) u_sd (
    .mem_store     (mem_store),
    .mem_sdata_reg (mem_sdata_reg),
    .wb_dst        (wb_dst),
    .wb_wr         (wb_wr),
    .sd_fwd        (sd_fwd)
  );

endmodule

// File: rtl/hz_fwd_unit_chk.sv
module hz_fwd_unit_chk #(
  parameter int unsigned REG_W        = 5,
  parameter bit          STORE_FWD_EN = 1'b1
) (
  input logic [REG_W-1:0] id_src1,
  input logic [REG_W-1:0] id_src2,
  input logic             id_src1_used,
  input logic             id_store,
  input logic [REG_W-1:0] ex_src1,
  input logic [REG_W-1:0] ex_src2,
  input logic             ex_load,
  input logic [REG_W-1:0] ex_dst,
  input logic             mem_load,
  input logic             mem_store,
  input logic [REG_W-1:0] mem_sdata_reg,
  input logic [1:0]       fwd_a_sel,
  input logic [1:0]       fwd_b_sel,
  input logic             sd_fwd,
  input logic             pc_hold,
  input logic             ifid_hold,
  input logic             idex_bubble,
  input logic             lu_base_hit,
  input logic             lu_data_hit
);

  always_comb begin
    if (!$isunknown({fwd_a_sel, fwd_b_sel, sd_fwd, pc_hold, ifid_hold,
                     idex_bubble, ex_load, mem_load, mem_store, id_store,
                     id_src1, id_src2, id_src1_used, ex_src1, ex_src2,
                     ex_dst, mem_sdata_reg, lu_base_hit, lu_data_hit})) begin
      // R1: register 0 never forwards
      a_r1_zero_src_a: assert (!(ex_src1 == '0 && fwd_a_sel != 2'b00));
      a_r1_zero_src_b: assert (!(ex_src2 == '0 && fwd_b_sel != 2'b00));
      a_r1_zero_sd:    assert (!(mem_sdata_reg == '0 && sd_fwd));
      // R2: only three legal select codes
      a_r2_legal_a: assert (fwd_a_sel != 2'b11);
      a_r2_legal_b: assert (fwd_b_sel != 2'b11);
      // R3: a load in memory never feeds execute from its own stage
      a_r3_no_load_exm: assert (!(mem_load && (fwd_a_sel == 2'b10 || fwd_b_sel == 2'b10)));
      // R4: the three front-end controls move together
      a_r4_hold_group: assert (pc_hold == ifid_hold && ifid_hold == idex_bubble);
      // R6: a base match against a load always holds
      a_r6_base_holds: assert (!lu_base_hit || pc_hold);
      // R5: with the late path a store data match alone does not hold
      a_r5_data_free: assert (!(STORE_FWD_EN && id_store && lu_data_hit && !lu_base_hit && pc_hold));
      // R7: store data forwarding needs a store in memory
      a_r7_needs_store: assert (!sd_fwd || (mem_store && STORE_FWD_EN));
      // R8: holds only arise from a load in execute
      a_r8_load_only: assert (!pc_hold || (ex_load && ex_dst != '0));
    end
  end

endmodule

bind hz_fwd_unit hz_fwd_unit_chk #(.REG_W(REG_W), .STORE_FWD_EN(STORE_FWD_EN)) chk_i (
  .id_src1       (id_src1),
  .id_src2       (id_src2),
  .id_src1_used  (id_src1_used),
  .id_store      (id_store),
  .ex_src1       (ex_src1),
  .ex_src2       (ex_src2),
  .ex_load       (ex_load),
  .ex_dst        (ex_dst),
  .mem_load      (mem_load),
  .mem_store     (mem_store),
  .mem_sdata_reg (mem_sdata_reg),
  .fwd_a_sel     (fwd_a_sel),
  .fwd_b_sel     (fwd_b_sel),
  .sd_fwd        (sd_fwd),
  .pc_hold       (pc_hold),
  .ifid_hold     (ifid_hold),
  .idex_bubble   (idex_bubble),
  .lu_base_hit   (lu_base_hit),
  .lu_data_hit   (lu_data_hit)
);

// File: tb/hz_fwd_unit_tb_top.sv
module hz_fwd_unit_tb_top;

  localparam int unsigned REG_W   = 5;
  localparam int unsigned CLK_PER = 10;

  logic clk = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  logic [REG_W-1:0] id_src1, id_src2, ex_src1, ex_src2, ex_dst, mem_dst, mem_sdata_reg, wb_dst;
  logic id_src1_used, id_src2_used, id_store, ex_src1_used, ex_src2_used;
  logic ex_wr, ex_load, mem_wr, mem_load, mem_store, wb_wr;

  logic [1:0] fa1, fb1, fa0, fb0;
  logic sd1, sd0, ph1, ih1, bb1, ph0, ih0, bb0;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  hz_fwd_unit #(.REG_W(REG_W), .STORE_FWD_EN(1'b1)) dut_i (
    .id_src1(id_src1), .id_src2(id_src2), .id_src1_used(id_src1_used),
    .id_src2_used(id_src2_used), .id_store(id_store),
    .ex_src1(ex_src1), .ex_src2(ex_src2), .ex_src1_used(ex_src1_used),
    .ex_src2_used(ex_src2_used), .ex_dst(ex_dst), .ex_wr(ex_wr), .ex_load(ex_load),
    .mem_dst(mem_dst), .mem_wr(mem_wr), .mem_load(mem_load), .mem_store(mem_store),
    .mem_sdata_reg(mem_sdata_reg), .wb_dst(wb_dst), .wb_wr(wb_wr),
    .fwd_a_sel(fa1), .fwd_b_sel(fb1), .sd_fwd(sd1),
    .pc_hold(ph1), .ifid_hold(ih1), .idex_bubble(bb1)
  );

  hz_fwd_unit #(.REG_W(REG_W), .STORE_FWD_EN(1'b0)) dut_base_i (
    .id_src1(id_src1), .id_src2(id_src2), .id_src1_used(id_src1_used),
    .id_src2_used(id_src2_used), .id_store(id_store),
    .ex_src1(ex_src1), .ex_src2(ex_src2), .ex_src1_used(ex_src1_used),
    .ex_src2_used(ex_src2_used), .ex_dst(ex_dst), .ex_wr(ex_wr), .ex_load(ex_load),
    .mem_dst(mem_dst), .mem_wr(mem_wr), .mem_load(mem_load), .mem_store(mem_store),
    .mem_sdata_reg(mem_sdata_reg), .wb_dst(wb_dst), .wb_wr(wb_wr),
    .fwd_a_sel(fa0), .fwd_b_sel(fb0), .sd_fwd(sd0),
    .pc_hold(ph0), .ifid_hold(ih0), .idex_bubble(bb0)
  );

  // Expected operand select, restated as a lookup over the writer stages.
  function automatic logic [1:0] exp_sel(logic [REG_W-1:0] s, logic used);
    logic [1:0] r;
    r = 2'b00;
    if (used && s != 0) begin
      if (wb_wr && wb_dst == s) r = 2'b01;
      if (mem_wr && mem_dst == s) r = mem_load ? 2'b00 : 2'b10;
    end
    return r;
  endfunction

  function automatic logic exp_hold(bit late);
    logic b, d;
    if (!(ex_load && ex_wr) || ex_dst == 0) return 1'b0;
    b = id_src1_used && id_src1 == ex_dst;
    d = id_src2_used && id_src2 == ex_dst;
    if (late && id_store) return b;
    return b | d;
  endfunction

  function automatic logic exp_sd(bit late);
    return late && mem_store && wb_wr && mem_sdata_reg != 0 && mem_sdata_reg == wb_dst;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_all();
    {id_src1, id_src2, ex_src1, ex_src2, ex_dst, mem_dst, mem_sdata_reg, wb_dst} = '0;
    {id_src1_used, id_src2_used, id_store, ex_src1_used, ex_src2_used} = '0;
    {ex_wr, ex_load, mem_wr, mem_load, mem_store, wb_wr} = '0;
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic check_model(string tag);
    chk({tag, " R2 a"}, fa1, exp_sel(ex_src1, ex_src1_used));
    chk({tag, " R2 b"}, fb1, exp_sel(ex_src2, ex_src2_used));
    chk({tag, " R2 base a"}, fa0, exp_sel(ex_src1, ex_src1_used));
    chk({tag, " R4 hold"}, {ph1, ih1, bb1}, {3{exp_hold(1'b1)}});
    chk({tag, " R5 base hold"}, {ph0, ih0, bb0}, {3{exp_hold(1'b0)}});
    chk({tag, " R7 sd"}, sd1, exp_sd(1'b1));
    chk({tag, " R7 base sd"}, sd0, 0);
  endtask

  initial begin
    #(CLK_PER * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    clear_all();
    settle();
    // Idle state
    chk("R2 idle a", fa1, 0);
    chk("R4 idle hold", ph1, 0);
    chk("R7 idle sd", sd1, 0);

    // R1: everything points at register 0
    ex_src1 = 0; ex_src1_used = 1; mem_dst = 0; mem_wr = 1; wb_dst = 0; wb_wr = 1;
    ex_load = 1; ex_wr = 1; ex_dst = 0; id_src1 = 0; id_src1_used = 1;
    mem_store = 1; mem_sdata_reg = 0;
    settle();
    chk("R1 sel", fa1, 0);
    chk("R1 hold", ph1, 0);
    chk("R1 sd", sd1, 0);

    // R2: memory stage beats writeback
    clear_all();
    ex_src1 = 7; ex_src1_used = 1; mem_dst = 7; mem_wr = 1; wb_dst = 7; wb_wr = 1;
    ex_src2 = 9; ex_src2_used = 1; wb_dst = 7;
    settle();
    chk("R2 exm priority", fa1, 2);
    mem_dst = 3; settle();
    chk("R2 wb", fa1, 1);

    // R3: load in memory shadows writeback
    mem_dst = 7; mem_load = 1; settle();
    chk("R3 shadow", fa1, 0);

    // R4: load then ALU use
    clear_all();
    ex_load = 1; ex_wr = 1; ex_dst = 5; id_src2 = 5; id_src2_used = 1;
    settle();
    chk("R4 alu hold", {ph1, ih1, bb1}, 3'b111);

    // R5: load then store of loaded value
    id_store = 1; id_src1 = 4; id_src1_used = 1; settle();
    chk("R5 late no hold", ph1, 0);
    chk("R5 base build hold", ph0, 1);

    // R6: load then store using loaded base
    id_src1 = 5; id_src2 = 6; settle();
    chk("R6 late hold", ph1, 1);
    chk("R6 base build hold", ph0, 1);

    // R7: store data forwarding in memory
    clear_all();
    mem_store = 1; mem_sdata_reg = 5; wb_wr = 1; wb_dst = 5; settle();
    chk("R7 sd on", sd1, 1);
    chk("R7 sd off base", sd0, 0);
    wb_wr = 0; settle();
    chk("R7 sd needs wr", sd1, 0);

    // R8: read-only sharing never holds
    clear_all();
    ex_wr = 1; ex_dst = 8; ex_src1 = 8; ex_src1_used = 1;
    id_src1 = 8; id_src1_used = 1; id_src2 = 8; id_src2_used = 1; settle();
    chk("R8 no hold", ph1, 0);

    // R9: unused sources ignored
    clear_all();
    ex_src1 = 6; ex_src1_used = 0; mem_dst = 6; mem_wr = 1;
    ex_load = 1; ex_wr = 1; ex_dst = 6; id_src1 = 6; id_src1_used = 0; settle();
    chk("R9 no fwd", fa1, 0);
    chk("R9 no hold", ph1, 0);

    // Random mix over a narrow register range
    for (int n = 0; n < 3000; n++) begin
      id_src1 = REG_W'($urandom_range(0, 3)); id_src2 = REG_W'($urandom_range(0, 3));
      ex_src1 = REG_W'($urandom_range(0, 3)); ex_src2 = REG_W'($urandom_range(0, 3));
      ex_dst = REG_W'($urandom_range(0, 3)); mem_dst = REG_W'($urandom_range(0, 3));
      mem_sdata_reg = REG_W'($urandom_range(0, 3)); wb_dst = REG_W'($urandom_range(0, 3));
      {id_src1_used, id_src2_used, id_store, ex_src1_used, ex_src2_used} = 5'($urandom);
      {ex_wr, ex_load, mem_wr, mem_load, mem_store, wb_wr} = 6'($urandom);
      settle();
      check_model("rand");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule